// File: doc/BRIEF.md
# Memory-Map and Receive-Delay Control Register

This block is one byte-wide configuration register on a CPU register bus, plus the decode logic that its fields drive. The upper nibble names the 4 KB page that holds a 768-byte EEPROM window. The window covers the top three 256-byte pages of that 4 KB page. The block compares the CPU address against it and drives an EEPROM select. After the first write in normal mode, this nibble can no longer be changed. The other fields stay writable.

A stretch bit and an external ROM-placement input together decide which external accesses get one extra E-clock cycle. The block raises a combinational stretch request for those accesses. Two delay bits select the start delay for a serial receiver. The block reports that delay as a number of 640 kHz prescaler ticks. When a receive-start trigger arrives, it counts that many ticks and then gives a one-cycle done pulse.

Top module: `memmap_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and the lock is clear.
- R2: Bit 2 is not stored and always reads as zero. Read data is {page[7:4], stretch_all[3], 0[2], delay_code[1:0]}.
- R3: In normal mode (special_mode low), the first write sets the lock. Once the lock is set, writes leave bits 7:4 unchanged, but bits 3, 1 and 0 of the same write still take effect. Only reset clears the lock.
- R4: While special_mode is high, writes always update bits 7:4 and never set the lock.
- R5: eeprom_sel is high exactly when cpu_addr[15:12] equals bits 7:4 and cpu_addr[11:8] is 0xD, 0xE or 0xF.
- R6: With bit 3 set, stretch_req is high for every external access that is not an EEPROM access.
- R7: With bit 3 clear, stretch_req is high for external accesses in 0x0000–0x1FFF when rom_low_map is 1. When rom_low_map is 0, it is high for accesses in 0xC000–0xDFFF.
- R8: stretch_req is low whenever ext_access is low or eeprom_sel is high.
- R9: delay_ticks equals (delay_code+1)×16. Codes 0..3 give 16, 32, 48 and 64 ticks.
- R10: After rx_start, delay_done pulses for one cycle. The pulse comes in the cycle after the tick_en that completes delay_ticks counted ticks. The tick count is captured at the trigger. A new rx_start restarts the count, and it takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | High in test modes; bypasses the lock |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read value |
| cpu_addr | input | 16 | Current CPU address |
| ext_access | input | 1 | Current access is not to an internal resource |
| rom_low_map | input | 1 | ROM-placement input: 1 = low region stretched, 0 = high region |
| eeprom_sel | output | 1 | Address falls in the EEPROM window |
| stretch_req | output | 1 | Add one E-clock cycle to this access |
| rx_start | input | 1 | Receive-start trigger |
| tick_en | input | 1 | 640 kHz prescaler tick enable |
| delay_ticks | output | 7 | Programmed receive delay in ticks |
| delay_done | output | 1 | One-cycle pulse when the delay ends |

## Verification
Addresses are taken just below, at and just above each edge of the EEPROM window. They are also taken at both edges of the two stretch regions. Each address is tried with each combination of the stretch bit, rom_low_map and ext_access, which separates an off-by-one range fault from a wrong-region or a missing-EEPROM-exclusion fault. Write sequences in normal mode, in special mode and mixed between the two show whether the lock blocks only the upper nibble and whether it is set only by normal-mode writes. The delay counter runs with each code and with sparse ticks, and with a mid-count restart, to expose errors in the count length, the pulse position and the reload.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
    localparam int ADDR_W     = 16;
    localparam int PAGE_W     = 4;
    localparam int DLY_CODE_W = 2;
    localparam int DLY_UNIT   = 16;

    typedef struct packed {
        logic [PAGE_W-1:0]     page;
        logic                  stretch_all;
        logic [DLY_CODE_W-1:0] dly_code;
        logic                  lock;
    } cfg_t;
endpackage

// File: rtl/memmap_cfgreg.sv
module memmap_cfgreg
    import memmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output cfg_t       cfg,
    output logic [7:0] rdata
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!cfg_q.lock || special_mode)
                cfg_d.page = wdata[7:4];
            cfg_d.stretch_all = wdata[3];
            cfg_d.dly_code    = wdata[1:0];
            if (!special_mode)
                cfg_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {cfg_q.page, cfg_q.stretch_all, 1'b0, cfg_q.dly_code};

    // Once locked, the lock stays set (R3)
    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> cfg_q.lock);
    // Locked page cannot change outside special mode (R3)
    assert_page_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lock && !special_mode) |=> $stable(cfg_q.page));
    // Special-mode writes never set the lock (R4)
    assert_special_nolock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (special_mode && !cfg_q.lock) |=> !cfg_q.lock);
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 4,
    parameter logic [3:0] EE_SUB_FIRST = 4'hD,
    parameter logic [15:0] LOW_END     = 16'h2000,
    parameter logic [15:0] HIGH_BASE   = 16'hC000,
    parameter logic [15:0] HIGH_END    = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] page,
    input  logic              stretch_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_access,
    input  logic              rom_low_map,
    output logic              eeprom_sel,
    output logic              stretch_req
);
    localparam int SUB_W = 4;

    logic [PAGE_W-1:0] addr_page;
    logic [SUB_W-1:0]  addr_sub;
    logic              in_low, in_high, in_region;

    always_comb begin
        addr_page  = addr[ADDR_W-1 -: PAGE_W];
        addr_sub   = addr[ADDR_W-PAGE_W-1 -: SUB_W];
        eeprom_sel = (addr_page == page) && (addr_sub >= EE_SUB_FIRST);
        in_low     = addr < LOW_END;
        in_high    = (addr >= HIGH_BASE) && (addr < HIGH_END);
        in_region  = rom_low_map ? in_low : in_high;
        stretch_req = ext_access && !eeprom_sel && (stretch_all || in_region);
    end

    // No stretch for internal or EEPROM accesses (R8)
    assert_no_stretch_internal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_req |-> (ext_access && !eeprom_sel));
    // Stretch-all covers every external non-EEPROM access (R6)
    assert_stretch_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_all && ext_access && !eeprom_sel) |-> stretch_req);
endmodule

// File: rtl/memmap_rxdelay.sv
module memmap_rxdelay #(
    parameter int CODE_W = 2,
    parameter int UNIT   = 16,
    parameter int CNT_W  = $clog2((2**CODE_W)*UNIT+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] dly_code,
    input  logic              rx_start,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  delay_ticks,
    output logic              delay_done
);
    localparam int MAX_TICKS = (2**CODE_W)*UNIT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        delay_ticks = CNT_W'((int'(dly_code) + 1) * UNIT);
        st_d        = st_q;
        st_d.done   = 1'b0;
        if (rx_start) begin
            st_d.cnt  = delay_ticks;
            st_d.busy = 1'b1;
        end else if (st_q.busy && tick_en) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.cnt  = '0;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign delay_done = st_q.done;

    // Done is a single-cycle pulse (R10)
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        delay_done |=> !delay_done);
    // Done only follows an active count (R10)
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delay_done) |-> $past(st_q.busy));
    // Running count stays inside its legal range (R9)
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0 && st_q.cnt <= CNT_W'(MAX_TICKS)));
endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
    import memmap_pkg::*;
#(
    parameter int DLY_UNIT_P = DLY_UNIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_mode,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              ext_access,
    input  logic              rom_low_map,
    output logic              eeprom_sel,
    output logic              stretch_req,
    input  logic              rx_start,
    input  logic              tick_en,
    output logic [$clog2((2**DLY_CODE_W)*DLY_UNIT_P+1)-1:0] delay_ticks,
    output logic              delay_done
);
    localparam int CNT_W = $clog2((2**DLY_CODE_W)*DLY_UNIT_P+1);

    cfg_t cfg;

    memmap_cfgreg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wr_en        (reg_wr),
        .wdata        (reg_wdata),
        .cfg          (cfg),
        .rdata        (reg_rdata)
    );

    memmap_decode #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .page        (cfg.page),
        .stretch_all (cfg.stretch_all),
        .addr        (cpu_addr),
        .ext_access  (ext_access),
        .rom_low_map (rom_low_map),
        .eeprom_sel  (eeprom_sel),
        .stretch_req (stretch_req)
    );

    memmap_rxdelay #(
        .CODE_W (DLY_CODE_W),
        .UNIT   (DLY_UNIT_P),
        .CNT_W  (CNT_W)
    ) u_dly (
        .clk         (clk),
        .rst_n       (rst_n),
        .dly_code    (cfg.dly_code),
        .rx_start    (rx_start),
        .tick_en     (tick_en),
        .delay_ticks (delay_ticks),
        .delay_done  (delay_done)
    );

    logic wbit2_unused;
    assign wbit2_unused = reg_wdata[2];

    // Bit 2 of the read value is never set (R2)
    assert_bit2_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_wr) |=> !reg_rdata[2]);
endmodule

// File: tb/tb_memmap_ctrl.sv
`timescale 1ns/1ps
module tb_memmap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic        ext_access = 1'b0;
    logic        rom_low_map = 1'b0;
    logic        eeprom_sel, stretch_req;
    logic        rx_start = 1'b0;
    logic        tick_en = 1'b0;
    logic [6:0]  delay_ticks;
    logic        delay_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int done_seen = 0;

    // Behavioural reference state
    int m_page, m_strx, m_code, m_lock, m_cnt, m_busy, m_done;

    memmap_ctrl dut (.*);

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_page = 0; m_strx = 0; m_code = 0; m_lock = 0;
            m_cnt = 0; m_busy = 0; m_done = 0;
        end else begin
            int ticks_now;
            ticks_now = (m_code + 1) * 16;
            m_done = 0;
            if (rx_start) begin
                m_cnt = ticks_now; m_busy = 1;
            end else if (m_busy != 0 && tick_en) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
            end
            if (reg_wr) begin
                if (m_lock == 0 || special_mode) m_page = reg_wdata[7:4];
                m_strx = reg_wdata[3];
                m_code = reg_wdata[1:0];
                if (!special_mode) m_lock = 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h, t=%0t)",
                     req, act, exp, cpu_addr, $time);
        end
    endtask

    always @(negedge clk) begin
        int a, esel, region, strq;
        cyc++;
        if (rst_n) begin
            a = int'(cpu_addr);
            esel = ((a >> 12) == m_page && ((a >> 8) & 15) >= 13) ? 1 : 0;
            region = rom_low_map ? (a < 'h2000) : (a >= 'hC000 && a < 'hE000);
            strq = (ext_access && esel == 0 && (m_strx != 0 || region != 0)) ? 1 : 0;
            check("R1 R2 R3 R4 read value", int'(reg_rdata),
                  m_page * 16 + m_strx * 8 + m_code);
            check("R5 eeprom select", int'(eeprom_sel), esel);
            check("R6 R7 R8 stretch", int'(stretch_req), strq);
            check("R9 delay ticks", int'(delay_ticks), (m_code + 1) * 16);
            check("R10 delay done", int'(delay_done), m_done);
            if (delay_done) done_seen++;
        end
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wdata = v; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic sweep();
        logic [15:0] addrs [12] = '{16'h0000, 16'h1FFF, 16'h2000, 16'hBFFF,
                                   16'hC000, 16'hDFFF, 16'hE000, 16'h5CFF,
                                   16'h5D00, 16'h5FFF, 16'h6000, 16'hCD00};
        for (int i = 0; i < 12; i++)
            for (int k = 0; k < 4; k++) begin
                cpu_addr = addrs[i];
                ext_access = k[0];
                rom_low_map = k[1];
                step();
            end
        ext_access = 1'b0;
    endtask

    task automatic run_delay(input int code, input int restart_after);
        int ticks;
        wr(8'(code));
        rx_start = 1'b1; step(); rx_start = 1'b0;
        ticks = 0;
        done_seen = 0;
        for (int c = 0; c < 400 && done_seen == 0; c++) begin
            tick_en = (c % 3 == 0);
            if (tick_en) ticks++;
            if (restart_after > 0 && ticks == restart_after) begin
                rx_start = 1'b1; restart_after = 0;
            end
            step();
            rx_start = 1'b0;
        end
        tick_en = 1'b0;
        step(); step();
        check("R10 done observed", done_seen, 1);
    endtask

    initial begin
        do_reset();
        // R1: reset value
        check("R1 reset read", int'(reg_rdata), 0);
        // R2 R3: first normal write, bit 2 dropped
        wr(8'h5F);
        check("R2 bit2 zero", int'(reg_rdata), 'h5B);
        // R3: page locked, lower bits still take effect
        wr(8'hA4);
        check("R3 locked page", int'(reg_rdata), 'h50);
        sweep();
        wr(8'h58);
        sweep();
        // R4: special mode bypasses lock
        special_mode = 1'b1;
        wr(8'hC0);
        check("R4 special write", int'(reg_rdata), 'hC0);
        special_mode = 1'b0;
        sweep();
        // R4: special writes do not lock; first normal write still lands
        do_reset();
        special_mode = 1'b1; wr(8'h30); special_mode = 1'b0;
        wr(8'h70);
        check("R4 no lock from special", int'(reg_rdata), 'h70);
        wr(8'h18);
        check("R3 lock after normal", int'(reg_rdata), 'h78);
        sweep();
        // R9 R10: delay codes and restart
        for (int c = 0; c < 4; c++) run_delay(c, 0);
        run_delay(1, 10);
        // R10: trigger and tick coinciding
        wr(8'h00);
        rx_start = 1'b1; tick_en = 1'b1; step();
        rx_start = 1'b0; tick_en = 1'b0;
        for (int c = 0; c < 60; c++) begin tick_en = c[0]; step(); end
        tick_en = 1'b0;
        step(); step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule